// File: doc/BRIEF.md
# Burst Transmit-Enable Sequencer with Gain Ramp

This block paces bursty transmission for one channel of a time-slotted upconverter. Once `start` is asserted it alternates between a guard interval, with `txen` low, and a burst interval, with `txen` high. Both lengths are given as clock counts. Every guard interval streams one complete stored configuration set out of a valid/ready port. The set holds fifteen register words, and the downstream datapath applies them before the next burst. The block keeps eight such sets and walks them in round-robin order, so consecutive bursts can carry different shaping settings.

The block also holds a gain table and produces a gain word that ramps the burst amplitude in and out. Each symbol strobe moves the table index one step. The index climbs while `txen` is high, up to a programmable top entry, and then holds there. It falls back toward entry zero once `txen` is low. When the profile is disabled, the gain word is full scale. The multiplication that applies this gain is done outside the block.

The configuration stream follows the usual rules. A word transfers on a cycle where `cfg_valid` and `cfg_ready` are both high. While it waits for `cfg_ready`, the block keeps `cfg_valid` high and holds `cfg_addr` steady. Back-pressure stretches the guard interval: `txen` cannot rise until the last word has been taken.

Top module: `burst_ramp_seq`

## Requirements
- R1: While reset is asserted, `txen` and `cfg_valid` are 0 and `gain_word` is 0.
- R2: With `start` low after reset, `txen` stays low and no configuration word is offered. Raising `start` begins a guard interval, never a burst.
- R3: Each burst keeps `txen` high for exactly max(`on_count`, 1) cycles.
- R4: A guard interval that ends in a burst keeps `txen` low for max(`off_count`, h+2) cycles, where h is the 0-based guard cycle in which the fifteenth word is accepted. `txen` never rises while a word of the current set is still pending.
- R5: Every guard interval transfers exactly fifteen words, with `cfg_addr` running 0, 1, ... 14 in that order.
- R6: `cfg_valid` is only high while `txen` is low. Once offered, a word stays offered with unchanged `cfg_addr` and `cfg_data` until it is accepted.
- R7: Guard intervals emit sets 0, 1, ... up to `last_set` and then wrap to 0; a pointer above `last_set` also wraps to 0. Each `cfg_data` equals the word last written at that set and index through the `cfg_wr_*` port.
- R8: Each `sym_stb` cycle moves the gain index. While `txen` is high it goes up by one until it reaches min(`ramp_last`, 191), then holds. While `txen` is low it goes down by one until it reaches 0. Without `sym_stb` it holds.
- R9: `gain_word` is registered. With `gain_en` high it equals the table entry at the index of the previous cycle. With `gain_en` low it is 16'h7FFF.
- R10: If `start` is low when a guard interval completes, the block goes idle. It finishes that set's fifteen words first, then raises `txen` no more and offers no further words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run enable, checked at each guard end |
| on_count | input | 16 | Burst length in clocks |
| off_count | input | 16 | Minimum guard length in clocks |
| last_set | input | 3 | Highest set index in the rotation |
| cfg_wr_en | input | 1 | Store a configuration word |
| cfg_wr_set | input | 3 | Set index for the store |
| cfg_wr_idx | input | 4 | Word index (0..14) for the store |
| cfg_wr_data | input | 16 | Word to store |
| gain_wr_en | input | 1 | Store a gain table entry |
| gain_wr_addr | input | 8 | Gain table entry (0..191) |
| gain_wr_data | input | 16 | Gain value to store |
| gain_en | input | 1 | Use the gain profile instead of full scale |
| ramp_last | input | 8 | Top entry of the ramp |
| sym_stb | input | 1 | Symbol-rate step strobe |
| cfg_ready | input | 1 | Downstream accepts the offered word |
| txen | output | 1 | Burst active |
| cfg_valid | output | 1 | Configuration word offered |
| cfg_addr | output | 4 | Register index of the offered word |
| cfg_data | output | 16 | Offered configuration word |
| gain_word | output | 16 | Current gain value |

## Verification
Random `cfg_ready` at 50 to 90 percent acceptance separates a guard that is limited by `off_count` from one that is stretched by stalled words. It also exercises the hold rules while a word is pending. A directed run with both counts at zero, `cfg_ready` tied high and `last_set` at 7 exposes the one-cycle burst, the sixteen-cycle guard floor and the full eight-set wrap. A long burst with the strobe always on and `ramp_last` at 191 drives the index into its top clamp. A disabled-profile run shows full scale regardless of the index. Stopping mid-run and restarting with a lower `last_set` checks the idle entry and the wrap of an out-of-range set pointer.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GUARD = 2'd1,
    PH_BURST = 2'd2
  } phase_t;
endpackage

// File: rtl/bts_phase_timer.sv
module bts_phase_timer
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] on_count,
  input  logic [CNT_W-1:0] off_count,
  input  logic             cfg_done,
  output logic             txen,
  output logic             in_guard,
  output logic             guard_exit
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_next;
  logic             on_done, off_done;

  // cnt holds the number of cycles already spent in the phase
  assign cnt_next   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign on_done    = cnt_next >= {1'b0, on_count};
  assign off_done   = cnt_next >= {1'b0, off_count};
  assign txen       = (phase == PH_BURST);
  assign in_guard   = (phase == PH_GUARD);
  assign guard_exit = in_guard && off_done && cfg_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) phase <= PH_GUARD;
        end
        PH_GUARD: begin
          if (guard_exit) begin
            phase <= start ? PH_BURST : PH_IDLE;
            cnt   <= '0;
          end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_BURST: begin
          if (on_done) begin
            phase <= PH_GUARD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bts_cfg_stream.sv
module bts_cfg_stream #(
  parameter int NUM_SETS = 8,
  parameter int REGS     = 15,
  parameter int DATA_W   = 16,
  parameter int SET_W    = 3,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SET_W-1:0]  last_set,
  input  logic              in_guard,
  input  logic              guard_exit,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int SETS2 = 1 << SET_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REGS);
  localparam logic [SET_W-1:0] TOP_SET  = SET_W'(NUM_SETS - 1);

  logic [DATA_W-1:0] mem [SETS2][SLOTS];
  logic [SET_W-1:0]  set_ptr;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < REGS) && (int'(wr_set) < NUM_SETS))
      mem[wr_set][wr_idx] <= wr_data;
  end

  assign done      = (idx == LAST_IDX);
  assign out_valid = in_guard && !done;
  assign out_addr  = idx;
  assign out_data  = mem[set_ptr][idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_ptr <= '0;
      idx     <= '0;
    end else if (guard_exit) begin
      idx     <= '0;
      set_ptr <= ((set_ptr >= last_set) || (set_ptr == TOP_SET)) ? '0 : set_ptr + 1'b1;
    end else if (out_valid && out_ready) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/bts_gain_ramp.sv
module bts_gain_ramp #(
  parameter int DEPTH  = 192,
  parameter int GAIN_W = 16,
  parameter int GIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GIDX_W-1:0] wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  input  logic              gain_en,
  input  logic [GIDX_W-1:0] ramp_last,
  input  logic              txen,
  input  logic              sym_stb,
  output logic [GAIN_W-1:0] gain_word,
  output logic [GIDX_W-1:0] gidx
);
  localparam logic [GIDX_W-1:0] TOP_ENTRY  = GIDX_W'(DEPTH - 1);
  localparam logic [GAIN_W-1:0] FULL_SCALE = {1'b0, {(GAIN_W-1){1'b1}}};

  logic [GAIN_W-1:0] table_q [DEPTH];
  logic [GIDX_W-1:0] top;

  assign top = (ramp_last > TOP_ENTRY) ? TOP_ENTRY : ramp_last;

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH))
      table_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gidx      <= '0;
      gain_word <= '0;
    end else begin
      gain_word <= gain_en ? table_q[gidx] : FULL_SCALE;
      if (sym_stb) begin
        if (txen && (gidx < top))
          gidx <= gidx + 1'b1;
        else if (!txen && (gidx != '0))
          gidx <= gidx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_ramp_seq.sv
module burst_ramp_seq #(
  parameter int CNT_W        = 16,
  parameter int NUM_SETS     = 8,
  parameter int REGS_PER_SET = 15,
  parameter int CFG_DW       = 16,
  parameter int GAIN_DEPTH   = 192,
  parameter int GAIN_W       = 16,
  parameter int SET_W        = $clog2(NUM_SETS),
  parameter int IDX_W        = $clog2(REGS_PER_SET + 1),
  parameter int GIDX_W       = $clog2(GAIN_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  on_count,
  input  logic [CNT_W-1:0]  off_count,
  input  logic [SET_W-1:0]  last_set,
  input  logic              cfg_wr_en,
  input  logic [SET_W-1:0]  cfg_wr_set,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [CFG_DW-1:0] cfg_wr_data,
  input  logic              gain_wr_en,
  input  logic [GIDX_W-1:0] gain_wr_addr,
  input  logic [GAIN_W-1:0] gain_wr_data,
  input  logic              gain_en,
  input  logic [GIDX_W-1:0] ramp_last,
  input  logic              sym_stb,
  input  logic              cfg_ready,
  output logic              txen,
  output logic              cfg_valid,
  output logic [IDX_W-1:0]  cfg_addr,
  output logic [CFG_DW-1:0] cfg_data,
  output logic [GAIN_W-1:0] gain_word
);
  logic              in_guard, guard_exit, cfg_done;
  logic [GIDX_W-1:0] gain_idx;

  bts_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .on_count(on_count), .off_count(off_count), .cfg_done(cfg_done),
    .txen(txen), .in_guard(in_guard), .guard_exit(guard_exit)
  );

  bts_cfg_stream #(
    .NUM_SETS(NUM_SETS), .REGS(REGS_PER_SET), .DATA_W(CFG_DW),
    .SET_W(SET_W), .IDX_W(IDX_W)
  ) u_stream (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_set(cfg_wr_set), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
    .last_set(last_set), .in_guard(in_guard), .guard_exit(guard_exit),
    .out_ready(cfg_ready), .out_valid(cfg_valid), .out_addr(cfg_addr),
    .out_data(cfg_data), .done(cfg_done)
  );

  bts_gain_ramp #(.DEPTH(GAIN_DEPTH), .GAIN_W(GAIN_W), .GIDX_W(GIDX_W)) u_gain (
    .clk(clk), .rst_n(rst_n),
    .wr_en(gain_wr_en), .wr_addr(gain_wr_addr), .wr_data(gain_wr_data),
    .gain_en(gain_en), .ramp_last(ramp_last), .txen(txen), .sym_stb(sym_stb),
    .gain_word(gain_word), .gidx(gain_idx)
  );
endmodule

// File: rtl/burst_ramp_seq_chk.sv
module burst_ramp_seq_chk #(
  parameter int IDX_W  = 4,
  parameter int GAIN_W = 16,
  parameter int GIDX_W = 8,
  parameter int REGS   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txen,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [IDX_W-1:0]  cfg_addr,
  input logic              sym_stb,
  input logic              gain_en,
  input logic [GAIN_W-1:0] gain_word,
  input logic [GIDX_W-1:0] gidx
);
  localparam logic [GAIN_W-1:0] FULL_SCALE = {1'b0, {(GAIN_W-1){1'b1}}};

  assert_valid_in_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !txen);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr)));

  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (int'(cfg_addr) < REGS));

  assert_rise_after_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen) |-> !$past(cfg_valid));

  assert_index_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> $stable(gidx));

  assert_full_scale_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_en |=> (gain_word == FULL_SCALE));
endmodule

bind burst_ramp_seq burst_ramp_seq_chk #(
  .IDX_W(IDX_W), .GAIN_W(GAIN_W), .GIDX_W(GIDX_W), .REGS(REGS_PER_SET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .txen(txen), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .sym_stb(sym_stb),
  .gain_en(gain_en), .gain_word(gain_word), .gidx(gain_idx)
);

// File: tb/burst_ramp_seq_tb.sv
module burst_ramp_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] on_count = 16'd40, off_count = 16'd20;
  logic [2:0]  last_set = 3'd2;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_set = '0;
  logic [3:0]  cfg_wr_idx = '0;
  logic [15:0] cfg_wr_data = '0;
  logic        gain_wr_en = 1'b0;
  logic [7:0]  gain_wr_addr = '0;
  logic [15:0] gain_wr_data = '0;
  logic        gain_en = 1'b1;
  logic [7:0]  ramp_last = 8'd5;
  logic        sym_stb = 1'b0;
  logic        cfg_ready = 1'b0;
  logic        txen, cfg_valid;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_data, gain_word;

  always #5 clk = ~clk;

  burst_ramp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .on_count(on_count), .off_count(off_count),
    .last_set(last_set), .cfg_wr_en(cfg_wr_en), .cfg_wr_set(cfg_wr_set),
    .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data), .gain_wr_en(gain_wr_en),
    .gain_wr_addr(gain_wr_addr), .gain_wr_data(gain_wr_data), .gain_en(gain_en),
    .ramp_last(ramp_last), .sym_stb(sym_stb), .cfg_ready(cfg_ready), .txen(txen),
    .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .gain_word(gain_word)
  );

  int n_checks = 0, n_fail = 0;
  logic [15:0] cmem [128];
  logic [15:0] tbl [192];
  int rdy_pct = 0, stb_pct = 0;
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int next_set(input int p, input int last);
    return (p >= last || p == 7) ? 0 : p + 1;
  endfunction

  // random handshake and strobe drivers
  initial begin
    forever begin
      @(posedge clk); #1;
      cfg_ready = ($urandom % 100) < rdy_pct;
      sym_stb   = ($urandom % 100) < stb_pct;
    end
  end

  // monitor and reference model
  int lo_len = 0, hi_len = 0, h_idx = 0, exp_idx = 0, exp_set = 0;
  int n_fall = 0, n_rise = 0, n_validc = 0, m_idx = 0, m_prev = 0, rlc = 0;
  bit after_burst = 0, p_tx = 0, p_stb = 0, p_gen = 0, p_rst = 0, p_val = 0, p_rdy = 0;
  int p_rl = 0;
  logic [3:0]  p_addr = '0;
  logic [15:0] p_data = '0, expg = '0;

  always @(negedge clk) begin
    if (mon_en && p_rst) begin
      m_prev = m_idx;
      rlc = (p_rl > 191) ? 191 : p_rl;
      if (p_tx && p_stb && m_idx < rlc) m_idx++;
      else if (!p_tx && p_stb && m_idx > 0) m_idx--;
      expg = p_gen ? tbl[m_prev] : 16'h7FFF;
      chk(gain_word === expg, p_gen ? "R8 gain ramp" : "R9 full scale", gain_word, expg);

      if (txen) begin
        if (!p_tx) begin
          n_rise++;
          chk(exp_idx == 15, "R4 set complete before rise", exp_idx, 15);
          if (after_burst)
            chk(lo_len == imax(int'(off_count), h_idx + 2), "R4 guard length",
                lo_len, imax(int'(off_count), h_idx + 2));
          exp_set = next_set(exp_set, int'(last_set));
          exp_idx = 0;
          hi_len = 1;
        end else hi_len++;
      end else begin
        if (p_tx) begin
          n_fall++;
          chk(hi_len == imax(int'(on_count), 1), "R3 burst length", hi_len,
              imax(int'(on_count), 1));
          lo_len = 1;
          after_burst = 1;
        end else lo_len++;
      end

      if (cfg_valid) begin
        n_validc++;
        chk(!txen, "R6 valid only in guard", txen, 0);
      end
      if (p_val && !p_rdy)
        chk(cfg_valid && cfg_addr == p_addr && cfg_data == p_data, "R6 stall hold",
            {cfg_valid, cfg_addr, cfg_data}, {1'b1, p_addr, p_data});
      if (cfg_valid && cfg_ready) begin
        chk(int'(cfg_addr) == exp_idx, "R5 word order", cfg_addr, exp_idx);
        chk(cfg_data === cmem[exp_set*16 + exp_idx], "R7 set data", cfg_data,
            cmem[exp_set*16 + exp_idx]);
        if (exp_idx == 14) h_idx = lo_len - 1;
        exp_idx++;
      end
    end else begin
      m_idx = 0;
    end
    p_rst = rst_n; p_tx = txen; p_stb = sym_stb; p_gen = gain_en; p_rl = int'(ramp_last);
    p_val = cfg_valid; p_rdy = cfg_ready; p_addr = cfg_addr; p_data = cfg_data;
  end

  task automatic run_bursts(input int nb);
    int tgt;
    tgt = n_fall + nb;
    start = 1'b1;
    while (n_fall < tgt) @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic settle_idle();
    int nr, nv;
    nr = n_rise;
    repeat (200) @(posedge clk);
    chk(n_rise == nr, "R10 no burst after stop", n_rise, nr);
    chk(exp_idx == 15, "R10 final set finished", exp_idx, 15);
    nv = n_validc;
    repeat (20) @(posedge clk);
    chk(n_validc == nv, "R10 no words while idle", n_validc, nv);
    exp_set = next_set(exp_set, int'(last_set));
    exp_idx = 0;
    after_burst = 0;
    #1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // load tables while held in reset
    @(posedge clk); #1;
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 15; i++) begin
        cmem[s*16 + i] = {s[3:0], i[3:0], 8'($urandom)};
        cfg_wr_en = 1'b1; cfg_wr_set = s[2:0]; cfg_wr_idx = i[3:0];
        cfg_wr_data = cmem[s*16 + i];
        @(posedge clk); #1;
      end
    end
    cfg_wr_en = 1'b0;
    for (int g = 0; g < 192; g++) begin
      tbl[g] = 16'($urandom);
      gain_wr_en = 1'b1; gain_wr_addr = g[7:0]; gain_wr_data = tbl[g];
      @(posedge clk); #1;
    end
    gain_wr_en = 1'b0;
    @(negedge clk);
    chk(txen == 1'b0, "R1 reset txen", txen, 0);
    chk(cfg_valid == 1'b0, "R1 reset valid", cfg_valid, 0);
    chk(gain_word == 16'h0, "R1 reset gain", gain_word, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R2: idle after reset
    repeat (20) @(posedge clk);
    chk(n_rise == 0, "R2 idle no burst", n_rise, 0);
    chk(n_validc == 0, "R2 idle no words", n_validc, 0);
    #1;

    // random back-pressure, three-set rotation, short ramp
    rdy_pct = 70; stb_pct = 60;
    run_bursts(7);
    settle_idle();

    // zero counts, always ready, all eight sets
    on_count = 16'd0; off_count = 16'd0; last_set = 3'd7;
    rdy_pct = 100; stb_pct = 100; ramp_last = 8'd191;
    run_bursts(10);
    settle_idle();

    // long burst to reach the top clamp, pointer above a lowered last_set
    on_count = 16'd300; off_count = 16'd30; last_set = 3'd1;
    rdy_pct = 50; stb_pct = 100;
    run_bursts(3);
    settle_idle();

    // profile disabled
    gain_en = 1'b0; on_count = 16'd25; off_count = 16'd18; last_set = 3'd3;
    rdy_pct = 90; stb_pct = 50; ramp_last = 8'd9;
    run_bursts(4);
    settle_idle();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule